// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns an issued load or store instruction into a memory request. A 40-bit instruction word has two 20-bit halves. A three-bit mode field in the low half picks where the 20-bit address comes from. It can be an absolute address carried in the high half of the word. It can be the stack pointer. It can also be the index register plus a signed displacement taken from the instruction.

In stack mode the block also works out the new stack pointer. A push is a store: it decrements the pointer first and writes at the decremented address. A pop is a load: it reads at the current pointer and then increments it. The register file owns the stack pointer, so the block only presents the new value together with a write strobe.

The request is held until the memory controller acknowledges it. A completion pulse then goes to the result write-back logic. Mode codes with no meaning raise an error pulse and start no memory cycle.

Top module: `ls_addr_gen`

## Requirements
- R1: The mode field is instruction bits 12:10, with code 0 for absolute, 1 for stack and 2 for indexed. Instruction bit 13 is the direction: 1 means store (or push), 0 means load (or pop). mem_we_o carries the direction of the accepted instruction.
- R2: In absolute mode the address is instruction bits 39:20.
- R3: A stack push (mode 1, bit 13 = 1) addresses sp_i - 1 and reports sp_o = sp_i - 1, wrapping modulo 2^20.
- R4: A stack pop (mode 1, bit 13 = 0) addresses sp_i and reports sp_o = sp_i + 1, wrapping modulo 2^20.
- R5: In indexed mode the address is idx_i plus instruction bits 9:0 taken as a signed two's-complement displacement sign-extended to 20 bits, with the sum wrapping modulo 2^20.
- R6: Mode codes 3 to 7 make err_o high for exactly the one cycle after the issue edge. They produce no mem_req_o and no done_o.
- R7: mem_req_o rises in the cycle after an accepted issue. It stays high, with mem_addr_o and mem_we_o unchanged, until the edge at which mem_ack_i is sampled high.
- R8: done_o is a single-cycle pulse in the cycle after the acknowledging edge. mem_req_o is low in that same cycle.
- R9: sp_we_o pulses together with done_o for stack-mode accesses only.
- R10: issue_i is ignored while busy_o is high. Such an issue changes neither the address in flight nor the number of done pulses.
- R11: After reset, mem_req_o, done_o, err_o, sp_we_o and busy_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction issue strobe |
| instr_i | input | 40 | Issued instruction word |
| sp_i | input | 20 | Current stack pointer |
| idx_i | input | 20 | Current index register |
| busy_o | output | 1 | Access in flight |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 20 | Request address |
| mem_ack_i | input | 1 | Memory acknowledge |
| done_o | output | 1 | Completion pulse to write-back |
| err_o | output | 1 | Illegal mode pulse |
| sp_o | output | 20 | Updated stack pointer |
| sp_we_o | output | 1 | Stack pointer write strobe |

## Verification
The assertions are evaluated on every cycle. They check the request handshake: the request is held with a stable address and direction until it is acknowledged, done follows the acknowledge, and every request is preceded by an issue. They also check that error and completion never occur together, and that a stack-pointer strobe always comes with a done pulse and a new pointer consistent with the address and direction. Only the bench scenarios can show that each mode selects the correct source value. The bench also covers the wrap-around at both ends of the address space, the sign extension of negative displacements, and the way an issue arriving during a held request is dropped.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  typedef enum logic [2:0] {
    MODE_ABS = 3'd0,
    MODE_STK = 3'd1,
    MODE_IDX = 3'd2
  } lsag_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } lsag_state_e;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode #(
  parameter int ADDR_W   = 20,
  parameter int MODE_LSB = 10
) (
  input  logic [2*ADDR_W-1:0] instr_i,
  output lsag_pkg::lsag_mode_e mode_o,
  output logic                legal_o,
  output logic                store_o,
  output logic [ADDR_W-1:0]   abs_o,
  output logic [ADDR_W-1:0]   disp_o
);
  import lsag_pkg::*;
  localparam int DISP_W  = MODE_LSB;
  localparam int DIR_BIT = MODE_LSB + 3;

  logic [2:0]        mode_raw;
  logic [DISP_W-1:0] disp_raw;
  logic              unused_bits;

  assign mode_raw    = instr_i[MODE_LSB+2:MODE_LSB];
  assign disp_raw    = instr_i[DISP_W-1:0];
  assign store_o     = instr_i[DIR_BIT];
  assign abs_o       = instr_i[2*ADDR_W-1:ADDR_W];
  assign legal_o     = (mode_raw <= 3'd2);
  assign mode_o      = lsag_mode_e'(mode_raw);
  assign unused_bits = ^instr_i[ADDR_W-1:DIR_BIT+1];

  generate
    if (DISP_W < ADDR_W) begin : g_sext
      assign disp_o = {{(ADDR_W-DISP_W){disp_raw[DISP_W-1]}}, disp_raw};
    end else begin : g_trunc
      assign disp_o = disp_raw[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lsag_addr_unit.sv
module lsag_addr_unit #(
  parameter int ADDR_W = 20
) (
  input  lsag_pkg::lsag_mode_e mode_i,
  input  logic                store_i,
  input  logic [ADDR_W-1:0]   abs_i,
  input  logic [ADDR_W-1:0]   disp_i,
  input  logic [ADDR_W-1:0]   sp_i,
  input  logic [ADDR_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [ADDR_W-1:0]   sp_next_o,
  output logic                stack_o
);
  import lsag_pkg::*;
  logic [ADDR_W-1:0] sp_dec, sp_inc;

  assign sp_dec = sp_i - ADDR_W'(1);
  assign sp_inc = sp_i + ADDR_W'(1);

  always_comb begin
    stack_o   = 1'b0;
    sp_next_o = sp_i;
    unique case (mode_i)
      MODE_STK: begin
        stack_o   = 1'b1;
        // push: pre-decrement; pop: use then increment
        addr_o    = store_i ? sp_dec : sp_i;
        sp_next_o = store_i ? sp_dec : sp_inc;
      end
      MODE_IDX: addr_o = idx_i + disp_i;
      default:  addr_o = abs_i;
    endcase
  end
endmodule

// File: rtl/lsag_ctrl.sv
module lsag_ctrl #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              legal_i,
  input  logic              stack_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] sp_next_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              sp_we_o
);
  import lsag_pkg::*;
  lsag_state_e       state_q;
  logic [ADDR_W-1:0] addr_q, sp_q;
  logic              we_q, stk_q, done_q, err_q, sp_we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      sp_q    <= '0;
      we_q    <= 1'b0;
      stk_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      sp_we_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      sp_we_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (issue_i) begin
            if (legal_i) begin
              state_q <= ST_REQ;
              addr_q  <= addr_i;
              we_q    <= store_i;
              stk_q   <= stack_i;
              if (stack_i) sp_q <= sp_next_i;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_REQ: begin
          if (mem_ack_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            sp_we_q <= stk_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == ST_REQ);
  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign sp_o       = sp_q;
  assign sp_we_o    = sp_we_q;
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int ADDR_W   = 20,
  parameter int MODE_LSB = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_i,
  input  logic [2*ADDR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]   sp_i,
  input  logic [ADDR_W-1:0]   idx_i,
  output logic                busy_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_ack_i,
  output logic                done_o,
  output logic                err_o,
  output logic [ADDR_W-1:0]   sp_o,
  output logic                sp_we_o
);
  import lsag_pkg::*;
  lsag_mode_e        mode;
  logic              legal, store, stack;
  logic [ADDR_W-1:0] abs_addr, disp, addr, sp_next;

  lsag_decode #(.ADDR_W(ADDR_W), .MODE_LSB(MODE_LSB)) u_dec (
    .instr_i (instr_i),
    .mode_o  (mode),
    .legal_o (legal),
    .store_o (store),
    .abs_o   (abs_addr),
    .disp_o  (disp)
  );

  lsag_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .mode_i    (mode),
    .store_i   (store),
    .abs_i     (abs_addr),
    .disp_i    (disp),
    .sp_i      (sp_i),
    .idx_i     (idx_i),
    .addr_o    (addr),
    .sp_next_o (sp_next),
    .stack_o   (stack)
  );

  lsag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue_i),
    .legal_i    (legal),
    .stack_i    (stack),
    .store_i    (store),
    .addr_i     (addr),
    .sp_next_i  (sp_next),
    .mem_ack_i  (mem_ack_i),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .sp_o       (sp_o),
    .sp_we_o    (sp_we_o)
  );
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              sp_we_o
);
  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r7_req_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(issue_i));

  a_r8_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> done_o && !mem_req_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_err_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o && !busy_o);

  a_r6_err_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_o, done_o}));

  a_r9_spwe_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> done_o);

  // R3 / R4: new pointer consistent with address and direction
  a_r3_r4_sp_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> (mem_we_o ? (sp_o == mem_addr_o) : (sp_o == mem_addr_o + ADDR_W'(1))));
endmodule

bind ls_addr_gen lsag_checker #(.ADDR_W(ADDR_W)) u_lsag_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .issue_i    (issue_i),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .done_o     (done_o),
  .err_o      (err_o),
  .sp_o       (sp_o),
  .sp_we_o    (sp_we_o)
);

// File: tb/ls_addr_gen_test.sv
module ls_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [39:0] instr = '0;
  logic [19:0] sp = '0, idx = '0;
  logic        ack = 1'b0;
  logic        busy, req, we, done, err, sp_we;
  logic [19:0] addr, sp_out;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  ls_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .instr_i(instr),
    .sp_i(sp), .idx_i(idx), .busy_o(busy), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_ack_i(ack), .done_o(done), .err_o(err),
    .sp_o(sp_out), .sp_we_o(sp_we)
  );

  typedef struct packed {
    logic [19:0] abs_f;
    logic        dir;
    logic [2:0]  mode;
    logic [9:0]  disp;
    logic [19:0] sp_v;
    logic [19:0] idx_v;
    logic [19:0] ea;
    logic        spw;
    logic [19:0] esp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{20'h12345, 1'b0, 3'd0, 10'h000, 20'h00000, 20'h00000, 20'h12345, 1'b0, 20'h0},     // R2 load
    '{20'hFFFFF, 1'b1, 3'd0, 10'h155, 20'h00010, 20'h00020, 20'hFFFFF, 1'b0, 20'h0},     // R2 store
    '{20'hAAAAA, 1'b1, 3'd1, 10'h000, 20'h00400, 20'h00000, 20'h003FF, 1'b1, 20'h003FF}, // R3 push
    '{20'hAAAAA, 1'b0, 3'd1, 10'h000, 20'h00400, 20'h00000, 20'h00400, 1'b1, 20'h00401}, // R4 pop
    '{20'hAAAAA, 1'b1, 3'd1, 10'h000, 20'h00000, 20'h00000, 20'hFFFFF, 1'b1, 20'hFFFFF}, // R3 wrap
    '{20'hAAAAA, 1'b0, 3'd1, 10'h000, 20'hFFFFF, 20'h00000, 20'hFFFFF, 1'b1, 20'h00000}, // R4 wrap
    '{20'h55555, 1'b0, 3'd2, 10'h07F, 20'h00000, 20'h01000, 20'h0107F, 1'b0, 20'h0},     // R5 pos
    '{20'h55555, 1'b0, 3'd2, 10'h3FF, 20'h00000, 20'h01000, 20'h00FFF, 1'b0, 20'h0},     // R5 -1
    '{20'h55555, 1'b0, 3'd2, 10'h020, 20'h00000, 20'hFFFF0, 20'h00010, 1'b0, 20'h0},     // R5 wrap up
    '{20'h55555, 1'b0, 3'd2, 10'h200, 20'h00000, 20'h00005, 20'hFFE05, 1'b0, 20'h0},     // R5 wrap down
    '{20'h55555, 1'b1, 3'd2, 10'h001, 20'h00000, 20'h00000, 20'h00001, 1'b0, 20'h0}      // R1 store idx
  };

  task automatic chk(input bit ok, input string rq, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [39:0] mk(vec_t v);
    return {v.abs_f, 6'b0, v.dir, v.mode, v.disp};
  endfunction

  task automatic access(input vec_t v, input int dly);
    @(negedge clk);
    instr = mk(v); sp = v.sp_v; idx = v.idx_v; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0; sp = ~sp; idx = ~idx;
    chk(req === 1'b1, "R7 req", 40'(req), 40'd1);
    chk(addr === v.ea, "R2/R3/R4/R5 addr", 40'(addr), 40'(v.ea));
    chk(we === v.dir, "R1 we", 40'(we), 40'(v.dir));
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(req === 1'b1 && addr === v.ea && !done, "R7 hold", 40'(addr), 40'(v.ea));
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(done === 1'b1 && req === 1'b0, "R8 done", {38'd0, done, req}, 40'd2);
    chk(sp_we === v.spw, "R9 sp_we", 40'(sp_we), 40'(v.spw));
    if (v.spw) chk(sp_out === v.esp, "R3/R4 sp", 40'(sp_out), 40'(v.esp));
    @(negedge clk);
    chk(done === 1'b0 && sp_we === 1'b0, "R8 pulse", {38'd0, done, sp_we}, 40'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({req, done, err, sp_we, busy} === 5'b0, "R11 reset", 40'({req, done, err, sp_we, busy}), 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({req, done, err, sp_we, busy} === 5'b0, "R11 after reset", 40'({req, done, err, sp_we, busy}), 40'd0);

    for (int i = 0; i < NV; i++) access(VEC[i], i % 3);

    // R6: illegal modes
    for (int m = 3; m < 8; m++) begin
      @(negedge clk);
      instr = {20'h12345, 6'b0, 1'b1, 3'(m), 10'h0}; issue = 1'b1;
      @(negedge clk);
      issue = 1'b0;
      chk(err === 1'b1 && req === 1'b0, "R6 err", {38'd0, err, req}, 40'd2);
      @(negedge clk);
      chk(err === 1'b0 && req === 1'b0 && done === 1'b0, "R6 no req", {37'd0, err, req, done}, 40'd0);
    end

    // R10: issue during held request
    @(negedge clk);
    instr = mk(VEC[0]); issue = 1'b1;
    @(negedge clk);
    instr = mk(VEC[2]); sp = 20'h00400;
    @(negedge clk);
    issue = 1'b0;
    chk(addr === 20'h12345 && req === 1'b1, "R10 addr kept", 40'(addr), 40'h12345);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(done === 1'b1 && sp_we === 1'b0, "R10 done no sp", {38'd0, done, sp_we}, 40'd2);
    repeat (2) begin
      @(negedge clk);
      chk(req === 1'b0 && busy === 1'b0 && done === 1'b0, "R10 no second access",
          {37'd0, req, busy, done}, 40'd0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 40'd0, 40'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule